// File: doc/BRIEF.md
# Mailbox I2C Bus Master

This block is an I2C bus master that software drives through six 16-bit registers. A command moves at most two data bytes. Software first places the outgoing bytes in a staging register. It then writes a command word that names the 7-bit target, the direction and the byte count, and says whether the bus stays claimed afterwards. The engine produces START, the address byte, the data bytes with their acknowledge bits, and STOP. SCL and SDA are driven open-drain.

When a command ends, one event bit in the status register is raised. A clean write raises the transmit event, a clean read raises the receive event, and a missing acknowledge raises the error event. Each event stays set until software writes a one to it. An enable mask turns the events into a level interrupt.

Setting the keep-bus flag leaves out STOP, so the following command joins the same transfer with a repeated START. A typical use is a register offset followed by a read. A read with the no-data flag set sends only the address byte and works as a presence probe.

The register port has no back-pressure: a write is taken on every cycle in which `reg_wr` is high. Reads are combinational. There is no data stream at the edge of the block.

Top module: `i2c_mbox_master`

## Requirements
- R1: After reset every register reads zero. The byte offsets are 0x0 status, 0x2 enable, 0x4 outgoing bytes, 0x6 command, 0x8 incoming bytes and 0xA command echo. The enable register keeps only bits 15:13, and all its other bits read 0. Offsets 0x6 and 0xA both read back the last accepted command word.
- R2: Command word fields: bits 6:0 are the target address; bit 10 = 1 selects write and bit 10 = 0 selects read; bit 11 = 1 selects two bytes, else one; bit 12 = 1 selects no data bytes (this overrides bit 11); bit 13 = 1 keeps the bus. A command whose bits 15:14 are not binary 10 is ignored, with no bus activity and no change to any register.
- R3: A write command sends START, then the address byte {addr, 0}, then outgoing byte 7:0, then (for two bytes) outgoing byte 15:8. Every byte goes MSB first. The transmit event (status bit 14) is then set.
- R4: A read command sends the address byte {addr, 1} and receives the data bytes. The first byte received lands in incoming bits 7:0 and the second in bits 15:8; unreceived bits are 0. The receive event (status bit 15) is then set.
- R5: On a read, the master drives ACK (SDA low) after each byte, except after the last byte of a command that does not keep the bus, where it leaves NACK (SDA released).
- R6: A NACK on the address byte or on a written byte ends the command with STOP. It sets the error event (status bit 13) and neither the transmit nor the receive event.
- R7: A command with the keep-bus flag ends without STOP, with SCL held low. The next command opens with a repeated START and no STOP in between.
- R8: A no-data read sends START, the address byte and STOP. It sets the receive event if the address was acknowledged, and the error event if it was not.
- R9: Writing the status register clears exactly those event bits that are written as one.
- R10: `irq` is high while any status event bit is set together with its enable bit at the same position.
- R11: A command written while a transaction is in progress is ignored: it starts no bus activity and leaves the command readback unchanged.
- R12: Inside a bit, SDA changes only while SCL is low; only START and STOP move SDA with SCL high. When the block is idle and not keeping the bus, both lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, taken every cycle it is high |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Level interrupt: enabled event pending |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sampled level of the SDA line |

## Verification
A behavioural target on the bench decodes the wire-level sequence into START, repeated START, STOP, address, written byte and master-acknowledge items. These items are compared with a queue that the command driver fills beforehand. One-byte and two-byte transfers in each direction separate the byte-order and count decoding. Keep-bus chains, first write-then-read and then read-then-read, separate repeated START from STOP and check which byte the master NACKs. Probes to a present and an absent address, and a target that refuses written data, separate the error path from the normal events. Back-to-back command writes and a command with a wrong mode field show that rejected commands leave the bus silent.

// File: rtl/i2cmb_pkg.sv
package i2cmb_pkg;
  localparam int REG_AW = 4;
  localparam int REG_DW = 16;

  localparam logic [REG_AW-1:0] OFS_STATUS = 4'h0;
  localparam logic [REG_AW-1:0] OFS_ENABLE = 4'h2;
  localparam logic [REG_AW-1:0] OFS_TXBUF  = 4'h4;
  localparam logic [REG_AW-1:0] OFS_CMD    = 4'h6;
  localparam logic [REG_AW-1:0] OFS_RXBUF  = 4'h8;
  localparam logic [REG_AW-1:0] OFS_ECHO   = 4'hA;

  // event bit positions in the status register
  localparam int EV_LO  = 13;     // error, then transmit, then receive
  localparam int EV_NUM = 3;

  // command word fields
  localparam int CB_WRITE  = 10;
  localparam int CB_TWO    = 11;
  localparam int CB_NODATA = 12;
  localparam int CB_KEEP   = 13;
  localparam logic [1:0] CMD_MODE_OK = 2'b10;

  typedef struct packed {
    logic [6:0] addr;
    logic       rd;
    logic [1:0] nbytes;
    logic       keep;
  } xfer_cmd_t;

  typedef enum logic [2:0] {
    ENG_IDLE, ENG_START, ENG_BIT, ENG_STOP, ENG_DONE
  } eng_state_e;
endpackage

// File: rtl/i2cmb_tick.sv
module i2cmb_tick #(
  parameter int QUARTER_CYCLES = 63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (QUARTER_CYCLES > 1) ? $clog2(QUARTER_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUARTER_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run)         cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/i2cmb_engine.sv
module i2cmb_engine
  import i2cmb_pkg::*;
#(
  parameter int QUARTER_CYCLES = 63
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  xfer_cmd_t   cmd,
  input  logic [15:0] wdata,
  input  logic        sda_i,
  output logic        busy,
  output logic        held,
  output logic        in_bit,
  output logic        done,
  output logic        err,
  output logic [15:0] rdata,
  output logic        scl_oe,
  output logic        sda_oe
);
  eng_state_e  state;
  xfer_cmd_t   cur;
  logic [15:0] wbuf;
  logic [1:0]  phase;
  logic [1:0]  slot;
  logic [3:0]  bitidx;
  logic [8:0]  tx9, rx9;
  logic        scl_drv, sda_drv;
  logic        tick, run, ack_checked;

  // nine bits per slot: eight data bits then the acknowledge bit
  function automatic logic [8:0] slot_word(input xfer_cmd_t c, input logic [15:0] wb,
                                           input logic [1:0] s);
    if (s == 2'd0)  return {c.addr, c.rd, 1'b1};
    else if (!c.rd) return {(s == 2'd1) ? wb[7:0] : wb[15:8], 1'b1};
    else            return {8'hFF, (s == c.nbytes) && !c.keep};
  endfunction

  assign run = (state == ENG_START) || (state == ENG_BIT) || (state == ENG_STOP);

  i2cmb_tick #(.QUARTER_CYCLES(QUARTER_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  assign ack_checked = (slot == 2'd0) || !cur.rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ENG_IDLE;
      cur     <= '0;
      wbuf    <= '0;
      phase   <= '0;
      slot    <= '0;
      bitidx  <= '0;
      tx9     <= '1;
      rx9     <= '0;
      scl_drv <= 1'b0;
      sda_drv <= 1'b0;
      held    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ENG_IDLE: if (start) begin
          cur   <= cmd;
          wbuf  <= wdata;
          err   <= 1'b0;
          rdata <= '0;
          phase <= '0;
          slot  <= '0;
          state <= ENG_START;
        end
        ENG_START: if (tick) begin
          phase <= phase + 1'b1;
          case (phase)
            2'd0: sda_drv <= 1'b0;     // SDA high while SCL is still low
            2'd1: scl_drv <= 1'b0;
            2'd2: sda_drv <= 1'b1;     // START edge
            default: begin
              scl_drv <= 1'b1;
              tx9     <= slot_word(cur, wbuf, 2'd0);
              bitidx  <= '0;
              state   <= ENG_BIT;
            end
          endcase
        end
        ENG_BIT: if (tick) begin
          phase <= phase + 1'b1;
          case (phase)
            2'd0: sda_drv <= ~tx9[8];
            2'd1: scl_drv <= 1'b0;
            2'd2: rx9     <= {rx9[7:0], sda_i};
            default: begin
              scl_drv <= 1'b1;
              tx9     <= {tx9[7:0], 1'b1};
              if (bitidx == 4'd8) begin
                if (ack_checked && rx9[0]) begin
                  err   <= 1'b1;
                  state <= ENG_STOP;
                end else begin
                  if (cur.rd && slot == 2'd1) rdata[7:0]  <= rx9[8:1];
                  if (cur.rd && slot == 2'd2) rdata[15:8] <= rx9[8:1];
                  if (slot == cur.nbytes) begin
                    if (cur.keep) begin
                      held  <= 1'b1;
                      state <= ENG_DONE;
                    end else begin
                      state <= ENG_STOP;
                    end
                  end else begin
                    slot   <= slot + 1'b1;
                    tx9    <= slot_word(cur, wbuf, slot + 1'b1);
                    bitidx <= '0;
                  end
                end
              end else begin
                bitidx <= bitidx + 1'b1;
              end
            end
          endcase
        end
        ENG_STOP: if (tick) begin
          phase <= phase + 1'b1;
          case (phase)
            2'd0: sda_drv <= 1'b1;
            2'd1: scl_drv <= 1'b0;
            2'd2: sda_drv <= 1'b0;     // STOP edge
            default: begin
              held  <= 1'b0;
              state <= ENG_DONE;
            end
          endcase
        end
        default: begin
          done  <= 1'b1;
          state <= ENG_IDLE;
        end
      endcase
    end
  end

  assign busy   = (state != ENG_IDLE);
  assign in_bit = (state == ENG_BIT);
  assign scl_oe = scl_drv;
  assign sda_oe = sda_drv;
endmodule

// File: rtl/i2cmb_regs.sv
module i2cmb_regs
  import i2cmb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_AW-1:0]   addr,
  input  logic [REG_DW-1:0]   wdata,
  output logic [REG_DW-1:0]   rdata,
  input  logic                eng_busy,
  input  logic                eng_done,
  input  logic                eng_err,
  input  logic [REG_DW-1:0]   eng_rdata,
  output logic                eng_start,
  output xfer_cmd_t           eng_cmd,
  output logic [REG_DW-1:0]   txbuf,
  output logic [EV_NUM-1:0]   events,
  output logic                irq
);
  logic [EV_NUM-1:0] ev_q, en_q, ev_set, ev_clr;
  logic [REG_DW-1:0] txbuf_q, rxbuf_q, cmd_q;
  logic              cmd_wr;

  assign cmd_wr    = wr_en && (addr == OFS_CMD);
  assign eng_start = cmd_wr && !eng_busy && (wdata[15:14] == CMD_MODE_OK);

  always_comb begin
    eng_cmd.addr   = wdata[6:0];
    eng_cmd.rd     = ~wdata[CB_WRITE];
    eng_cmd.keep   = wdata[CB_KEEP];
    if (wdata[CB_NODATA])    eng_cmd.nbytes = 2'd0;
    else if (wdata[CB_TWO])  eng_cmd.nbytes = 2'd2;
    else                     eng_cmd.nbytes = 2'd1;
  end

  // {receive, transmit, error}
  always_comb begin
    ev_set = '0;
    if (eng_done) begin
      if (eng_err)              ev_set = 3'b001;
      else if (cmd_q[CB_WRITE]) ev_set = 3'b010;
      else                      ev_set = 3'b100;
    end
    ev_clr = (wr_en && addr == OFS_STATUS) ? wdata[EV_LO +: EV_NUM] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q    <= '0;
      en_q    <= '0;
      txbuf_q <= '0;
      rxbuf_q <= '0;
      cmd_q   <= '0;
    end else begin
      ev_q <= (ev_q & ~ev_clr) | ev_set;
      if (wr_en && addr == OFS_ENABLE) en_q    <= wdata[EV_LO +: EV_NUM];
      if (wr_en && addr == OFS_TXBUF)  txbuf_q <= wdata;
      if (eng_start)                   cmd_q   <= wdata;
      if (eng_done && !eng_err && !cmd_q[CB_WRITE]) rxbuf_q <= eng_rdata;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_STATUS:       rdata[EV_LO +: EV_NUM] = ev_q;
      OFS_ENABLE:       rdata[EV_LO +: EV_NUM] = en_q;
      OFS_TXBUF:        rdata = txbuf_q;
      OFS_CMD, OFS_ECHO: rdata = cmd_q;
      OFS_RXBUF:        rdata = rxbuf_q;
      default:          rdata = '0;
    endcase
  end

  assign txbuf  = txbuf_q;
  assign events = ev_q;
  assign irq    = |(ev_q & en_q);
endmodule

// File: rtl/i2c_mbox_master.sv
module i2c_mbox_master
  import i2cmb_pkg::*;
#(
  parameter int QUARTER_CYCLES = 63
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_in
);
  logic              eng_busy, eng_held, eng_in_bit, eng_done, eng_err, eng_start;
  logic [15:0]       eng_rdata, txbuf;
  xfer_cmd_t         eng_cmd;
  logic [EV_NUM-1:0] ev_bits;

  i2cmb_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .eng_busy(eng_busy), .eng_done(eng_done), .eng_err(eng_err),
    .eng_rdata(eng_rdata), .eng_start(eng_start), .eng_cmd(eng_cmd),
    .txbuf(txbuf), .events(ev_bits), .irq(irq)
  );

  i2cmb_engine #(.QUARTER_CYCLES(QUARTER_CYCLES)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .start(eng_start), .cmd(eng_cmd), .wdata(txbuf), .sda_i(sda_in),
    .busy(eng_busy), .held(eng_held), .in_bit(eng_in_bit),
    .done(eng_done), .err(eng_err), .rdata(eng_rdata),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );
endmodule

// File: rtl/i2cmb_checker.sv
module i2cmb_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       in_bit,
  input logic       busy,
  input logic       held,
  input logic       start,
  input logic       done,
  input logic       err,
  input logic [2:0] ev
);
  AST_SDA_STEADY_WHILE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    in_bit && $past(in_bit) && !scl_oe && !$past(scl_oe) |-> $stable(sda_oe)); // R12
  AST_IDLE_LINES_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !held |-> !scl_oe && !sda_oe); // R12
  AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start); // R11
  AST_ERROR_RAISES_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    done && err |=> ev[0]); // R6
  AST_EVENT_ONLY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev & ~$past(ev)) != 3'b000 |-> $past(done)); // R3
endmodule

bind i2c_mbox_master i2cmb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .in_bit(eng_in_bit), .busy(eng_busy), .held(eng_held), .start(eng_start),
  .done(eng_done), .err(eng_err), .ev(ev_bits)
);

// File: tb/i2c_mbox_master_tb_top.sv
module i2c_mbox_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int QDIV = 4;
  localparam logic [6:0] TGT = 7'h50;
  localparam logic [3:0] K_S = 4'd1, K_R = 4'd2, K_P = 4'd3, K_A = 4'd4, K_W = 4'd5, K_M = 4'd6;
  localparam logic [15:0] MODE = 16'h8000, WR = 16'h0400, TWO = 16'h0800,
                          NOD = 16'h1000, KEEP = 16'h2000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic irq, scl_oe, sda_oe;
  logic slv_pull = 1'b0;
  logic scl, sda;

  assign scl = ~scl_oe;
  assign sda = ~(sda_oe | slv_pull);

  i2c_mbox_master #(.QUARTER_CYCLES(QDIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  bit finished = 1'b0;
  logic [11:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- target model and monitor ----------------
  logic pl = 1'b1, psd = 1'b1, in_txn = 1'b0, nack_data = 1'b0;
  logic addr_ok = 1'b0, rw = 1'b0, m_ack = 1'b1;
  logic [7:0] sh = '0, tx = '0, rd_val = 8'h81;
  int bitcnt = 0, mode = 0;   // 0 ignore, 1 address, 2 receive, 3 send

  function automatic logic [7:0] nxt(input logic [7:0] v);
    return {1'b1, v[6:0] + 7'd3};
  endfunction

  task automatic obs(input logic [3:0] k, input logic [7:0] v);
    logic [11:0] e;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R11", "unexpected bus item", int'({k, v}), 0);
    end else begin
      e = exp_q.pop_front();
      chk(e == {k, v}, "R3", "bus item", int'({k, v}), int'(e));
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (pl && scl && psd && !sda) begin
        obs(in_txn ? K_R : K_S, 8'h00);
        in_txn = 1'b1; mode = 1; bitcnt = 0; slv_pull = 1'b0;
      end else if (pl && scl && !psd && sda) begin
        obs(K_P, 8'h00);
        in_txn = 1'b0; mode = 0; bitcnt = 0; slv_pull = 1'b0;
      end else if (!pl && scl) begin
        if (bitcnt < 8) sh = {sh[6:0], sda};
        else if (mode == 3) begin m_ack = sda; obs(K_M, {7'd0, sda}); end
        bitcnt++;
      end else if (pl && !scl) begin
        if (bitcnt == 8) begin
          if (mode == 1) begin
            obs(K_A, sh); addr_ok = (sh[7:1] == TGT); rw = sh[0]; slv_pull = addr_ok;
          end else if (mode == 2) begin
            obs(K_W, sh); slv_pull = !nack_data;
          end else slv_pull = 1'b0;
        end else if (bitcnt == 9) begin
          bitcnt = 0;
          if (mode == 1) begin
            if (!addr_ok) mode = 0;
            else if (rw) begin mode = 3; tx = rd_val; rd_val = nxt(rd_val); end
            else mode = 2;
          end else if (mode == 3) begin
            if (!m_ack) begin tx = rd_val; rd_val = nxt(rd_val); end else mode = 0;
          end else if (mode == 2 && nack_data) mode = 0;
          slv_pull = (mode == 3) ? !tx[7] : 1'b0;
        end else if (mode == 3 && bitcnt < 8) begin
          slv_pull = !tx[7 - bitcnt];
        end
      end
      pl = scl; psd = sda;
    end
  end

  // ---------------- register driver ----------------
  task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic push(input logic [3:0] k, input logic [7:0] v);
    exp_q.push_back({k, v});
  endtask

  task automatic run_cmd(input logic [15:0] ext, input logic [15:0] cmd,
                         output logic [15:0] st);
    wr_reg(4'h4, ext);
    wr_reg(4'h6, cmd);
    st = '0;
    for (int i = 0; i < 5000 && st == 16'h0; i++) rd_reg(4'h0, st);
  endtask

  logic [15:0] v, st;
  logic [7:0] p0, p1, p2;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state and R12 idle lines
    for (int a = 0; a < 12; a += 2) begin
      rd_reg(4'(a), v);
      chk(v == 16'h0, "R1", "reset register value", v, 0);
    end
    chk(irq == 1'b0, "R10", "irq after reset", irq, 0);
    chk(scl && sda, "R12", "lines released after reset", {scl, sda}, 3);

    // R1 enable keeps only bits 15:13
    wr_reg(4'h2, 16'hFFFF); rd_reg(4'h2, v);
    chk(v == 16'hE000, "R1", "enable readback", v, 16'hE000);
    wr_reg(4'h2, 16'h0000);
    wr_reg(4'h4, 16'hBEEF); rd_reg(4'h4, v);
    chk(v == 16'hBEEF, "R1", "outgoing buffer readback", v, 16'hBEEF);

    // R3 two-byte write
    push(K_S, 0); push(K_A, {TGT, 1'b0}); push(K_W, 8'hEF); push(K_W, 8'hBE); push(K_P, 0);
    run_cmd(16'hBEEF, MODE | WR | TWO | 16'(TGT), st);
    chk(st == 16'h4000, "R3", "transmit event", st, 16'h4000);

    // R10 interrupt masking
    wr_reg(4'h2, 16'h4000);
    chk(irq == 1'b1, "R10", "irq with matching enable", irq, 1);
    wr_reg(4'h2, 16'hA000);
    chk(irq == 1'b0, "R10", "irq with other enables", irq, 0);
    wr_reg(4'h2, 16'h0000);

    // R9 write-one-to-clear
    wr_reg(4'h0, 16'hA000); rd_reg(4'h0, v);
    chk(v == 16'h4000, "R9", "clearing other bits leaves event", v, 16'h4000);
    wr_reg(4'h0, 16'h4000); rd_reg(4'h0, v);
    chk(v == 16'h0000, "R9", "event cleared", v, 0);

    // R4 two-byte read, R5 ACK then NACK
    p0 = rd_val; p1 = nxt(p0);
    push(K_S, 0); push(K_A, {TGT, 1'b1}); push(K_M, 0); push(K_M, 1); push(K_P, 0);
    run_cmd(16'h0, MODE | TWO | 16'(TGT), st);
    chk(st == 16'h8000, "R4", "receive event", st, 16'h8000);
    rd_reg(4'h8, v);
    chk(v == {p1, p0}, "R4", "incoming bytes order", v, {p1, p0});
    rd_reg(4'hA, v);
    chk(v == (MODE | TWO | 16'(TGT)), "R1", "command echo", v, MODE | TWO | 16'(TGT));
    wr_reg(4'h0, 16'hE000);

    // R5 one-byte read ends with NACK, high byte zero
    p0 = rd_val;
    push(K_S, 0); push(K_A, {TGT, 1'b1}); push(K_M, 1); push(K_P, 0);
    run_cmd(16'h0, MODE | 16'(TGT), st);
    rd_reg(4'h8, v);
    chk(v == {8'h00, p0}, "R5", "one-byte read data", v, {8'h00, p0});
    wr_reg(4'h0, 16'hE000);

    // R7 kept write then read with repeated START
    push(K_S, 0); push(K_A, {TGT, 1'b0}); push(K_W, 8'h12);
    run_cmd(16'h0012, MODE | WR | KEEP | 16'(TGT), st);
    chk(st == 16'h4000, "R7", "kept write event", st, 16'h4000);
    chk(!scl, "R7", "SCL held low while bus kept", scl, 0);
    wr_reg(4'h0, 16'hE000);
    p0 = rd_val; p1 = nxt(p0);
    push(K_R, 0); push(K_A, {TGT, 1'b1}); push(K_M, 0); push(K_M, 1); push(K_P, 0);
    run_cmd(16'h0, MODE | TWO | 16'(TGT), st);
    rd_reg(4'h8, v);
    chk(v == {p1, p0}, "R7", "read after repeated START", v, {p1, p0});
    wr_reg(4'h0, 16'hE000);

    // R5 kept read ACKs its last byte, R7 next read joins
    p0 = rd_val;
    push(K_S, 0); push(K_A, {TGT, 1'b1}); push(K_M, 0);
    run_cmd(16'h0, MODE | KEEP | 16'(TGT), st);
    rd_reg(4'h8, v);
    chk(v == {8'h00, p0}, "R5", "kept read data", v, {8'h00, p0});
    wr_reg(4'h0, 16'hE000);
    p2 = nxt(nxt(p0));
    push(K_R, 0); push(K_A, {TGT, 1'b1}); push(K_M, 1); push(K_P, 0);
    run_cmd(16'h0, MODE | 16'(TGT), st);
    rd_reg(4'h8, v);
    chk(v == {8'h00, p2}, "R7", "chained read data", v, {8'h00, p2});
    wr_reg(4'h0, 16'hE000);

    // R8 probe present and absent
    push(K_S, 0); push(K_A, {TGT, 1'b1}); push(K_P, 0);
    run_cmd(16'h0, MODE | NOD | 16'(TGT), st);
    chk(st == 16'h8000, "R8", "probe of present target", st, 16'h8000);
    wr_reg(4'h0, 16'hE000);
    push(K_S, 0); push(K_A, {7'h23, 1'b1}); push(K_P, 0);
    run_cmd(16'h0, MODE | NOD | 16'h0023, st);
    chk(st == 16'h2000, "R8", "probe of absent target", st, 16'h2000);
    wr_reg(4'h0, 16'hE000);

    // R6 target refuses written data
    nack_data = 1'b1;
    push(K_S, 0); push(K_A, {TGT, 1'b0}); push(K_W, 8'h34); push(K_P, 0);
    run_cmd(16'h5634, MODE | WR | TWO | 16'(TGT), st);
    chk(st == 16'h2000, "R6", "error event only", st, 16'h2000);
    nack_data = 1'b0;
    wr_reg(4'h0, 16'hE000);

    // R11 second command during transfer
    wr_reg(4'h4, 16'h0055);
    push(K_S, 0); push(K_A, {TGT, 1'b0}); push(K_W, 8'h55); push(K_P, 0);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 4'h6; reg_wdata = MODE | WR | 16'(TGT);
    @(negedge clk); reg_wdata = MODE | WR | 16'h0023;
    @(negedge clk); reg_wr = 1'b0;
    st = '0;
    for (int i = 0; i < 5000 && st == 16'h0; i++) rd_reg(4'h0, st);
    repeat (400) @(negedge clk);
    rd_reg(4'h0, v);
    chk(v == 16'h4000, "R11", "one event only", v, 16'h4000);
    rd_reg(4'h6, v);
    chk(v == (MODE | WR | 16'(TGT)), "R11", "readback keeps first", v, MODE | WR | 16'(TGT));
    wr_reg(4'h0, 16'hE000);

    // R2 wrong mode field is ignored
    wr_reg(4'h6, 16'h4000 | WR | 16'(TGT));
    repeat (400) @(negedge clk);
    rd_reg(4'h0, v);
    chk(v == 16'h0, "R2", "no event for bad mode", v, 0);
    rd_reg(4'h6, v);
    chk(v == (MODE | WR | 16'(TGT)), "R2", "readback unchanged", v, MODE | WR | 16'(TGT));

    chk(exp_q.size() == 0, "R3", "expected bus items left", exp_q.size(), 0);
    chk(scl && sda, "R12", "lines released at end", {scl, sda}, 3);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule